// File: doc/BRIEF.md
# Identification Mode Search Sequencer

This block runs the search for the broadcast identification tone that tells a two-carrier TV sound receiver whether the programme is mono, stereo or dual-language. It points an external narrow-band detector at one candidate at a time. The two candidates are the dual window and the stereo window, and the block switches between them after a dwell whose length software selects. The raw detect bit from the detector is never trusted directly. It feeds a saturating up/down integrator. The integrator declares a tone at an upper threshold and lets go of it only at a lower threshold.

Once a tone is declared, the scan freezes on the current window and the mode output reports that window. When the integrator drains to the lower threshold, the block clears the integrator, reports mono and resumes the scan from the other candidate with a full dwell. A mono-hold control forces the report to mono and parks the sequencer. All timing is counted in ticks of a timebase strobe. That strobe comes either from a line-rate reference, where every strobe counts, or from a reference at four times that rate, where every fourth strobe counts.

Top module: `idscan_seq`

## Requirements
- R1: After reset the mode output is mono (00) and the window select is 1 (dual window). The mode is encoded as 00 for mono, 01 for stereo and 10 for dual. The value 11 never appears.
- R2: A base tick is the unit of all timing. The dwell on each window is D base ticks, where D = UNIT for select 00, 2*UNIT for 01, 4*UNIT for 10, and 4*UNIT for 11. While nothing is locked, the window select toggles on the D-th base tick of a window.
- R3: With the fast-reference input at 0, every timebase strobe is a base tick. With it at 1, only every fourth strobe counted from reset is a base tick.
- R4: The upper threshold is HI = D - D/4. The mode changes on the HI-th consecutive detecting base tick counted from the start of a window. It becomes 10 in the dual window (select 1) and 01 in the stereo window (select 0). After HI-1 detecting base ticks the mode is still 00.
- R5: A detect bit that alternates on every base tick never produces a lock, and the window keeps alternating with the normal dwell.
- R6: While locked and the detect bit stays at 1, the window select and the mode do not change, however long the lock lasts.
- R7: The integrator saturates at D. Starting from saturation, the mode stays locked through HI-1 non-detecting base ticks.
- R8: On the HI-th non-detecting base tick after saturation (integrator at D/4), the mode returns to 00 and the window select flips to the other candidate. The next toggle comes after a full D base ticks.
- R9: While mono-hold is 1, the mode is 00 from the next clock on. The window does not move and no lock forms, even with detect at 1.
- R10: The window select changes only in a cycle that follows an edge with a timebase strobe present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timebase strobe |
| fast_ref_i | input | 1 | 1: strobes arrive at four times the line rate, so divide by 4 |
| raw_det_i | input | 1 | Raw sideband detect from the analog filter |
| period_sel_i | input | 2 | Dwell select (see R2) |
| mono_hold_i | input | 1 | Force and hold mono |
| win_dual_o | output | 1 | Window select: 1 dual, 0 stereo |
| mode_o | output | 2 | Reported mode: 00 mono, 01 stereo, 10 dual |

## Verification
The bench sweeps every period select, both reference rates and both target windows. This separates faults in the dwell shift from faults in the prescaler and in the window polarity. In each configuration it tries three detect patterns:
- A detect that alternates on every base tick must leave the scan untouched, which exposes a missing integrator.
- A steady detect is stepped up to one tick short of the upper threshold and then to the threshold itself, which pins the lock point.
- A steady absence after saturation is stepped to one tick short of the lower threshold and then to the threshold, which separates hysteresis from a single threshold.

A mono-hold applied on top of a lock tells a hold that only masks the output apart from one that really parks the sequencer.

// File: rtl/idscan_pkg.sv
package idscan_pkg;
  typedef enum logic [1:0] {
    MODE_MONO   = 2'b00,
    MODE_STEREO = 2'b01,
    MODE_DUAL   = 2'b10
  } mode_e;

  localparam int unsigned FAST_DIV  = 4;
  localparam int unsigned MAX_SHIFT = 2;
endpackage

// File: rtl/idscan_prescale.sv
module idscan_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic fast_i,
  output logic base_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase_q;

  assign base_o = tick_i & (~fast_i | (phase_q == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n || !fast_i) begin
      phase_q <= '0;
    end else if (tick_i) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/idscan_integ.sv
module idscan_integ #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          up_i,
  input  logic          hold_i,
  input  logic          wipe_i,
  input  logic [CW-1:0] len_i,
  output logic          locked_o,
  output logic          lock_ev_o,
  output logic          rel_ev_o
);
  logic [CW-1:0] acc_q, acc_nxt, thr_hi, thr_lo;

  assign thr_lo = len_i >> 2;
  assign thr_hi = len_i - thr_lo;

  always_comb begin
    if (up_i) acc_nxt = (acc_q >= len_i) ? len_i : acc_q + 1'b1;
    else      acc_nxt = (acc_q == '0) ? '0 : acc_q - 1'b1;
  end

  assign lock_ev_o = step_i & ~hold_i & ~locked_o & (acc_nxt >= thr_hi);
  assign rel_ev_o  = step_i & ~hold_i &  locked_o & (acc_nxt <= thr_lo);

  always_ff @(posedge clk) begin
    if (!rst_n || hold_i || rel_ev_o) begin
      acc_q    <= '0;
      locked_o <= 1'b0;
    end else if (lock_ev_o) begin
      acc_q    <= acc_nxt;
      locked_o <= 1'b1;
    end else if (wipe_i) begin
      acc_q    <= '0;
    end else if (step_i) begin
      acc_q    <= acc_nxt;
    end
  end
endmodule

// File: rtl/idscan_window.sv
module idscan_window #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          run_i,
  input  logic          flip_i,
  input  logic [CW-1:0] len_i,
  output logic          win_dual_o,
  output logic          end_ev_o
);
  logic [CW-1:0] cnt_q;

  assign end_ev_o = step_i & run_i & (cnt_q >= len_i - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      win_dual_o <= 1'b1;
    end else if (flip_i || end_ev_o) begin
      cnt_q      <= '0;
      win_dual_o <= ~win_dual_o;
    end else if (step_i && run_i) begin
      cnt_q      <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/idscan_seq.sv
module idscan_seq #(
  parameter int unsigned UNIT = 15625
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       fast_ref_i,
  input  logic       raw_det_i,
  input  logic [1:0] period_sel_i,
  input  logic       mono_hold_i,
  output logic       win_dual_o,
  output logic [1:0] mode_o
);
  import idscan_pkg::*;

  localparam int unsigned MAXLEN = UNIT << MAX_SHIFT;
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  logic          base_tick, step, locked, lock_ev, rel_ev, end_ev;
  logic [1:0]    shift;
  logic [CW-1:0] dwell_len;
  mode_e         mode_q;

  idscan_prescale #(.DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .fast_i(fast_ref_i),
    .base_o(base_tick)
  );

  assign shift     = (period_sel_i > 2'(MAX_SHIFT)) ? 2'(MAX_SHIFT) : period_sel_i;
  assign dwell_len = CW'(UNIT) << shift;
  assign step      = base_tick & ~mono_hold_i;

  idscan_integ #(.CW(CW)) u_integ (
    .clk(clk), .rst_n(rst_n), .step_i(step), .up_i(raw_det_i),
    .hold_i(mono_hold_i), .wipe_i(end_ev), .len_i(dwell_len),
    .locked_o(locked), .lock_ev_o(lock_ev), .rel_ev_o(rel_ev)
  );

  idscan_window #(.CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .step_i(step), .run_i(~locked & ~lock_ev),
    .flip_i(rel_ev), .len_i(dwell_len),
    .win_dual_o(win_dual_o), .end_ev_o(end_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || mono_hold_i || rel_ev) mode_q <= MODE_MONO;
    else if (lock_ev)                     mode_q <= win_dual_o ? MODE_DUAL : MODE_STEREO;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/idscan_chk.sv
module idscan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       mono_hold_i,
  input logic       win_dual_o,
  input logic [1:0] mode_o
);
  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);

  assert_lock_matches_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b00 && $past(mode_o) == 2'b00) |-> mode_o == (win_dual_o ? 2'b10 : 2'b01));

  assert_frozen_while_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b00) |=> (mode_o == 2'b00 || ($stable(mode_o) && $stable(win_dual_o))));

  assert_hold_forces_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mono_hold_i |=> mode_o == 2'b00);

  assert_window_moves_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(win_dual_o));
endmodule

bind idscan_seq idscan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mono_hold_i(mono_hold_i),
  .win_dual_o(win_dual_o), .mode_o(mode_o)
);

// File: tb/idscan_seq_tb_top.sv
module idscan_seq_tb_top;
  localparam int UNIT = 4;

  logic       clk = 1'b0;
  logic       rst_n, tick, fast, raw, hold;
  logic [1:0] sel;
  logic       win;
  logic [1:0] mode;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  idscan_seq #(.UNIT(UNIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .fast_ref_i(fast),
    .raw_det_i(raw), .period_sel_i(sel), .mono_hold_i(hold),
    .win_dual_o(win), .mode_o(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic count_flip(input int noise, input int mult, output int cnt);
    logic w0;
    w0 = win;
    cnt = 0;
    while (win == w0 && cnt < 2000) begin
      if (noise != 0) raw = ((cnt / mult) % 2 == 0);
      pulse(1);
      cnt++;
    end
    raw = 1'b0;
  endtask

  task automatic run(input int s, input int f, input int st);
    int mult, d, hi, c, expm;
    logic w;
    mult = f ? 4 : 1;
    d    = UNIT << ((s == 3) ? 2 : s);
    hi   = d - d / 4;
    rst_n = 1'b0; tick = 1'b0; raw = 1'b0; hold = 1'b0;
    sel = 2'(s); fast = f[0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset window", win, 1);
    repeat (40) @(negedge clk);
    chk("R10 no strobe keeps window", win, 1);

    count_flip(1, mult, c);
    chk("R2,R3 R5 dwell under alternating detect", c, d * mult);
    chk("R5 no lock from noise", mode, 0);
    count_flip(0, mult, c);
    chk("R2,R3 second dwell", c, d * mult);
    if (st != 0) count_flip(0, mult, c);
    w = win;
    expm = w ? 2 : 1;

    raw = 1'b1;
    pulse((hi - 1) * mult);
    chk("R4 one short of upper threshold", mode, 0);
    pulse(mult);
    chk("R4 lock at upper threshold", mode, expm);
    pulse(3 * d * mult);
    chk("R6 mode frozen", mode, expm);
    chk("R6 window frozen", win, w);

    raw = 1'b0;
    pulse((hi - 1) * mult);
    chk("R7 hysteresis holds lock", mode, expm);
    pulse(mult);
    chk("R8 release to mono", mode, 0);
    chk("R8 window flips on release", win, !w);
    count_flip(0, mult, c);
    chk("R8 full dwell after release", c, d * mult);

    raw = 1'b1;
    pulse(hi * mult);
    chk("R9 relock before hold", mode, expm);
    @(negedge clk) hold = 1'b1;
    @(negedge clk);
    chk("R9 hold forces mono", mode, 0);
    pulse(4 * d * mult);
    chk("R9 mono held", mode, 0);
    chk("R9 window parked", win, w);
    hold = 1'b0;
    raw = 1'b0;
  endtask

  task automatic finish_up();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 2; f++)
        for (int st = 0; st < 2; st++)
          run(s, f, st);
    finish_up();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end
endmodule